// File: doc/BRIEF.md
# Serial Control-Port Target for a Six-Register Regulator Bank

This block is the two-wire serial target that lets a host program a small bank of six byte-wide control registers inside a programmable voltage regulator. It oversamples the clock and data lines with the system clock. Each line goes through a synchronizer and a majority-free glitch filter. The block then recognises START, repeated START and STOP, and matches a 7-bit address whose low bit comes from a strap pin. It acknowledges by asserting an open-drain pull-low enable for the data line.

A write carries the target address, a register pointer and one data byte. A read first sets the pointer with a write-addressed frame, then issues a repeated START with the read address, and the target shifts the selected byte out. The block also spots the high-speed master code, which it never acknowledges, and raises a high-speed flag on the repeated START that follows. The flag drops at the next STOP.

The rest of the regulator sees every register value as seen by a reader, plus a one-cycle strobe per register each time a read loads that register. The bank has two voltage registers, a control register, two fixed identity bytes and a status register. A write of a set soft-reset bit restores every default and raises a sticky reset flag. That flag clears after the status register has been read.

Top module: `i2c_regbank_target`

## Requirements
- R1: After power-on reset the bank reads, from index 0 to 5: 0xC0, 0xC0, 0x82, 0x81, 0x08, 0x00 (voltage defaults are bit 7 set plus code 64), with the data line released and the high-speed flag low.
- R2: The target acknowledges the 7-bit address 0x60 when the strap is 0 and 0x61 when it is 1; any other address leaves the data line released (NACK) and changes no register.
- R3: A frame of START, address with write bit 0, pointer, data byte, STOP, with every byte sent MSB first, stores the data byte into the pointed register and acknowledges all three bytes.
- R4: A pointer write followed by a repeated START and the address with read bit 1 shifts the pointed register out MSB first and pulses that register's read strobe once; at most one read strobe is high at a time.
- R5: A pointer above 5 is not acknowledged, and the data byte that follows is not acknowledged either.
- R6: Writes to index 3 and 4 are acknowledged but leave them at 0x81 and 0x08; bit 3 of index 2 always reads 0.
- R7: Writing index 2 with bit 2 set restores all registers to their defaults, bit 2 of index 2 reads back 0, and bit 2 of index 5 becomes 1.
- R8: The reset flag in bit 2 of index 5 clears after index 5 has been read, so a second read returns 0 in that bit.
- R9: A byte of the form 00001xxx in the address slot is not acknowledged; the repeated START after it sets the high-speed flag, which stays high until the next STOP.
- R10: The target changes its data-line drive only while the filtered clock is low.
- R11: A clock-line pulse shorter than the filter window (two system clocks) produces no bit and does not corrupt a transfer.
- R12: Index 5 reads the external status input with bit 2 replaced by the reset flag; bit 2 of the status input is ignored.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| addr_alt | input | 1 | Strap: 1 selects the alternate address 0x61 |
| status_in | input | 8 | Regulator status bits shown in index 5 (bit 2 unused) |
| sda_oe | output | 1 | 1 pulls the data line low |
| hs_mode | output | 1 | High-speed mode active |
| bank_q | output | 48 | Reader view of all registers, index k in bits 8k+7..8k |
| rd_stb | output | 6 | One-cycle strobe per register when a read loads it |

## Verification
A corrupt link state shows at the ports within one byte. The acknowledge slot would come out wrong, or the data line would be driven during a byte the master owns, and the next acknowledge sample exposes that. A wrong bank state shows in `bank_q` on the cycle after the write strobe, and in the serial read-back of the same register one frame later. A stuck reset flag or a stuck high-speed flag shows at the second status read or at the first STOP, since both of those must clear it.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   localparam int NUM_REGS = 6;
   localparam int PTR_W    = 3;

   localparam logic [PTR_W-1:0] IDX_VOLT0 = 3'd0;
   localparam logic [PTR_W-1:0] IDX_VOLT1 = 3'd1;
   localparam logic [PTR_W-1:0] IDX_CTRL  = 3'd2;
   localparam logic [PTR_W-1:0] IDX_STAT  = 3'd5;

   localparam logic [7:0] ID_VENDOR  = 8'h81;
   localparam logic [7:0] ID_REV     = 8'h08;
   localparam logic [7:0] CTRL_DFLT  = 8'h82;

   localparam int SRST_BIT = 2;   // control: self-clearing soft reset
   localparam int RSVD_BIT = 3;   // control: always reads 0
   localparam int FLAG_BIT = 2;   // status: reset performed

   localparam logic [4:0] HS_CODE_TOP = 5'b00001;

   typedef enum logic [3:0] {
      LK_IDLE, LK_ADDR, LK_PTR, LK_WDAT, LK_ACKW, LK_ACK, LK_RD, LK_MACK, LK_IGN
   } link_st_e;

endpackage

// File: rtl/i2ct_filt.sv
module i2ct_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int SMSB = SYNC_STAGES - 1;

   logic [SMSB:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SMSB-1:0], din};
   end

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= 1'b1;
            else        dout <= sync_q[SMSB];
         end
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               dout   <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SMSB]};
               if (&hist_q)      dout <= 1'b1;
               else if (~|hist_q) dout <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
   import i2ct_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'h60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             sda_f,
   input  logic             addr_alt,
   input  logic [7:0]       rd_data,
   output logic             sda_oe,
   output logic             hs_mode,
   output logic             wr_stb,
   output logic [7:0]       wr_data,
   output logic             rd_stb,
   output logic [PTR_W-1:0] ptr,
   output logic             start_det,
   output logic             stop_det
);
   localparam logic [7:0] NREG8 = 8'(NUM_REGS);

   logic       scl_d, sda_d;
   logic       scl_rise, scl_fall;
   link_st_e   st_q, nxt_q;
   logic [2:0] bit_q;
   logic [7:0] sh_q;
   logic [7:0] byte_in;
   logic       hs_pend_q;
   logic [6:0] my_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
   assign byte_in   = {sh_q[6:0], sda_f};
   assign my_addr   = ADDR_BASE | {6'd0, addr_alt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= LK_IDLE;
         nxt_q     <= LK_IDLE;
         bit_q     <= '0;
         sh_q      <= '0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
         hs_mode   <= 1'b0;
         hs_pend_q <= 1'b0;
         wr_stb    <= 1'b0;
         wr_data   <= '0;
         rd_stb    <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (stop_det) begin
            st_q      <= LK_IDLE;
            sda_oe    <= 1'b0;
            hs_mode   <= 1'b0;
            hs_pend_q <= 1'b0;
         end else if (start_det) begin
            st_q   <= LK_ADDR;
            bit_q  <= '0;
            sda_oe <= 1'b0;
            if (hs_pend_q) begin
               hs_mode   <= 1'b1;
               hs_pend_q <= 1'b0;
            end
         end else begin
            case (st_q)
               LK_ADDR, LK_PTR, LK_WDAT: begin
                  if (scl_rise) begin
                     sh_q  <= byte_in;
                     bit_q <= bit_q + 3'd1;
                     if (bit_q == 3'd7) begin
                        if (st_q == LK_ADDR) begin
                           if (byte_in[7:1] == my_addr) begin
                              st_q  <= LK_ACKW;
                              nxt_q <= byte_in[0] ? LK_RD : LK_PTR;
                           end else begin
                              st_q <= LK_IGN;
                              if (byte_in[7:3] == HS_CODE_TOP && !hs_mode)
                                 hs_pend_q <= 1'b1;
                           end
                        end else if (st_q == LK_PTR) begin
                           if (byte_in < NREG8) begin
                              ptr   <= byte_in[PTR_W-1:0];
                              st_q  <= LK_ACKW;
                              nxt_q <= LK_WDAT;
                           end else begin
                              st_q <= LK_IGN;
                           end
                        end else begin
                           wr_stb  <= 1'b1;
                           wr_data <= byte_in;
                           st_q    <= LK_ACKW;
                           nxt_q   <= LK_IGN;
                        end
                     end
                  end
               end
               LK_ACKW: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b1;
                     st_q   <= LK_ACK;
                  end
               end
               LK_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (nxt_q == LK_RD) begin
                        sh_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                        rd_stb <= 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                     end
                     st_q <= nxt_q;
                  end
               end
               LK_RD: begin
                  if (scl_fall) begin
                     if (bit_q == 3'd7) begin
                        sda_oe <= 1'b0;
                        st_q   <= LK_MACK;
                     end else begin
                        sda_oe <= ~sh_q[6];
                        sh_q   <= {sh_q[6:0], 1'b0};
                        bit_q  <= bit_q + 3'd1;
                     end
                  end
               end
               LK_MACK: begin
                  if (scl_rise) st_q <= LK_IGN;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2ct_bank.sv
module i2ct_bank
   import i2ct_pkg::*;
#(
   parameter logic [6:0] DFLT_CODE0 = 7'd64,
   parameter logic [6:0] DFLT_CODE1 = 7'd64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_stb,
   input  logic [PTR_W-1:0]      wr_ptr,
   input  logic [7:0]            wr_data,
   input  logic [NUM_REGS-1:0]   rd_stb_vec,
   input  logic [7:0]            status_in,
   input  logic [PTR_W-1:0]      rd_ptr,
   output logic [7:0]            rd_data,
   output logic [8*NUM_REGS-1:0] bank_q
);
   localparam logic [7:0] VOLT0_DFLT = {1'b1, DFLT_CODE0};
   localparam logic [7:0] VOLT1_DFLT = {1'b1, DFLT_CODE1};
   localparam logic [7:0] CTRL_MASK  = ~((8'd1 << SRST_BIT) | (8'd1 << RSVD_BIT));

   logic [7:0] volt0_q, volt1_q, ctrl_q;
   logic       flag_q;
   logic       soft_rst;
   logic [7:0] view [NUM_REGS];

   assign soft_rst = wr_stb && (wr_ptr == IDX_CTRL) && wr_data[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         volt0_q <= VOLT0_DFLT;
         volt1_q <= VOLT1_DFLT;
         ctrl_q  <= CTRL_DFLT;
         flag_q  <= 1'b0;
      end else if (soft_rst) begin
         volt0_q <= VOLT0_DFLT;
         volt1_q <= VOLT1_DFLT;
         ctrl_q  <= CTRL_DFLT;
         flag_q  <= 1'b1;
      end else begin
         if (wr_stb) begin
            case (wr_ptr)
               IDX_VOLT0: volt0_q <= wr_data;
               IDX_VOLT1: volt1_q <= wr_data;
               IDX_CTRL:  ctrl_q  <= wr_data & CTRL_MASK;
               default: ;
            endcase
         end
         if (rd_stb_vec[IDX_STAT]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      view[0] = volt0_q;
      view[1] = volt1_q;
      view[2] = ctrl_q;
      view[3] = ID_VENDOR;
      view[4] = ID_REV;
      view[5] = status_in;
      view[5][FLAG_BIT] = flag_q;
   end

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_ptr == PTR_W'(k)) rd_data = view[k];
   end

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
         assign bank_q[8*g +: 8] = view[g];
      end
   endgenerate
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
   import i2ct_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE   = 7'h60,
   parameter logic [6:0] DFLT_CODE0  = 7'd64,
   parameter logic [6:0] DFLT_CODE1  = 7'd64,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  addr_alt,
   input  logic [7:0]            status_in,
   output logic                  sda_oe,
   output logic                  hs_mode,
   output logic [8*NUM_REGS-1:0] bank_q,
   output logic [NUM_REGS-1:0]   rd_stb
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (ADDR_BASE[0] != 1'b0) begin : g_bad_addr
         $error("ADDR_BASE bit 0 is taken by the strap and must be 0");
      end
   endgenerate

   logic [1:0]       raw_in, flt_out;
   logic             scl_flt, sda_flt;
   logic             lnk_wr, lnk_rd;
   logic [7:0]       lnk_wdata, bank_rdata;
   logic [PTR_W-1:0] lnk_ptr;
   logic             start_det, stop_det;

   assign raw_in = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_line
         i2ct_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst_n (rst_n),
            .din (raw_in[g]),
            .dout (flt_out[g])
         );
      end
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_rstb
         assign rd_stb[g] = lnk_rd & (lnk_ptr == PTR_W'(g));
      end
   endgenerate

   assign scl_flt = flt_out[0];
   assign sda_flt = flt_out[1];

   i2ct_link #(.ADDR_BASE(ADDR_BASE)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_flt),
      .sda_f     (sda_flt),
      .addr_alt  (addr_alt),
      .rd_data   (bank_rdata),
      .sda_oe    (sda_oe),
      .hs_mode   (hs_mode),
      .wr_stb    (lnk_wr),
      .wr_data   (lnk_wdata),
      .rd_stb    (lnk_rd),
      .ptr       (lnk_ptr),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2ct_bank #(.DFLT_CODE0(DFLT_CODE0), .DFLT_CODE1(DFLT_CODE1)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (lnk_wr),
      .wr_ptr     (lnk_ptr),
      .wr_data    (lnk_wdata),
      .rd_stb_vec (rd_stb),
      .status_in  (status_in),
      .rd_ptr     (lnk_ptr),
      .rd_data    (bank_rdata),
      .bank_q     (bank_q)
   );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_f,
   input logic        sda_oe,
   input logic        hs_mode,
   input logic        stop_det,
   input logic [47:0] bank_q,
   input logic [5:0]  rd_stb
);
   assert_oe_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_oe));

   assert_hs_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_mode) |-> $past(stop_det));

   assert_ctrl_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bank_q[19:18] == 2'b00);

   assert_id_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(bank_q[39:24]));

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_q[42]) |-> $past(rd_stb[5]));

   assert_rdstb_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_stb));
endmodule

bind i2c_regbank_target i2ct_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_flt),
   .sda_oe   (sda_oe),
   .hs_mode  (hs_mode),
   .stop_det (stop_det),
   .bank_q   (bank_q),
   .rd_stb   (rd_stb)
);

// File: tb/i2c_regbank_target_bench.sv
`timescale 1ns/1ps
module i2c_regbank_target_bench;
   localparam int Q = 16;
   localparam logic [47:0] DFLT = {8'h00, 8'h08, 8'h81, 8'h82, 8'hC0, 8'hC0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        addr_alt = 1'b0;
   logic [7:0]  status_in = 8'h00;
   logic        sda_oe, hs_mode;
   logic [47:0] bank_q;
   logic [5:0]  rd_stb;
   wire         sda_bus = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   i2c_regbank_target u_i2c_regbank_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .addr_alt(addr_alt), .status_in(status_in),
      .sda_oe(sda_oe), .hs_mode(hs_mode), .bank_q(bank_q), .rd_stb(rd_stb)
   );

   typedef struct { string tag; logic [7:0] val; } item_t;
   item_t      exp_q[$];
   logic [7:0] obs_q[$];
   item_t      e_it;
   logic [7:0] o_v;
   int checks = 0, errors = 0, rd0_cnt = 0, hi_cnt = 0, oe_viol = 0;
   logic prev_oe = 1'b0;
   bit glitch_next = 0, done = 0;
   logic [6:0] cur_addr = 7'h60;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (exp_q.size() > 0 && obs_q.size() > 0) begin
         e_it = exp_q.pop_front();
         o_v  = obs_q.pop_front();
         chk(e_it.tag, 64'(o_v), 64'(e_it.val));
      end
   end

   always @(negedge clk) begin
      if (rd_stb[0]) rd0_cnt++;
      hi_cnt = scl_m ? hi_cnt + 1 : 0;
      if (rst_n && hi_cnt > 12 && sda_oe !== prev_oe) oe_viol++;
      prev_oe = sda_oe;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(string tag, logic [7:0] v);
      item_t it;
      it.tag = tag; it.val = v;
      exp_q.push_back(it);
   endtask

   task automatic wbit(logic b);
      sda_m = b;
      if (glitch_next) begin
         tick(4); scl_m = 1'b1; tick(2); scl_m = 1'b0; glitch_next = 0; tick(Q - 6);
      end else tick(Q);
      scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
   endtask

   task automatic send(logic [7:0] b, string tag, logic exp_ack);
      logic a;
      for (int i = 7; i >= 0; i--) wbit(b[i]);
      rbit(a);
      push(tag, {7'd0, exp_ack});
      obs_q.push_back({7'd0, a});
   endtask

   task automatic recv(string tag, logic [7:0] expv);
      logic [7:0] v;
      logic b;
      for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
      wbit(1'b1);
      push(tag, expv);
      obs_q.push_back(v);
   endtask

   task automatic reg_write(logic [7:0] p, logic [7:0] d, string tag);
      bus_start(); send({cur_addr, 1'b0}, tag, 1'b0);
      send(p, tag, 1'b0); send(d, tag, 1'b0); bus_stop();
   endtask

   task automatic reg_read(logic [7:0] p, logic [7:0] expv, string tag);
      bus_start(); send({cur_addr, 1'b0}, tag, 1'b0); send(p, tag, 1'b0);
      bus_start(); send({cur_addr, 1'b1}, tag, 1'b0); recv(tag, expv); bus_stop();
   endtask

   initial begin
      tick(150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int rc;
      tick(5); rst_n = 1'b1; tick(10);
      // R1 reset state
      chk("R1 bank", 64'(bank_q), 64'(DFLT));
      chk("R1 oe", 64'(sda_oe), 64'd0);
      chk("R1 hs", 64'(hs_mode), 64'd0);

      // R3 write, R4 read back
      reg_write(8'h00, 8'h55, "R3");
      tick(4); chk("R3 reg0", 64'(bank_q[7:0]), 64'h55);
      rc = rd0_cnt;
      reg_read(8'h00, 8'h55, "R4");
      chk("R4 strobe", 64'(rd0_cnt - rc), 64'd1);

      // R2 address mismatch
      bus_start(); send({7'h23, 1'b0}, "R2 wrong", 1'b1); bus_stop();
      chk("R2 untouched", 64'(bank_q[7:0]), 64'h55);
      // R2 strap
      addr_alt = 1'b1; cur_addr = 7'h61;
      reg_write(8'h00, 8'h22, "R2 alt");
      tick(4); chk("R2 alt reg0", 64'(bank_q[7:0]), 64'h22);
      bus_start(); send({7'h60, 1'b0}, "R2 old", 1'b1); bus_stop();
      addr_alt = 1'b0; cur_addr = 7'h60;

      // R5 pointer out of range
      bus_start(); send(8'hC0, "R5", 1'b0); send(8'h07, "R5 ptr", 1'b1);
      send(8'h99, "R5 data", 1'b1); bus_stop();
      chk("R5 bank", 64'(bank_q[47:8]), 64'(DFLT[47:8]));

      // R6 read-only and reserved bit
      reg_write(8'h03, 8'hFF, "R6");
      reg_write(8'h04, 8'h00, "R6");
      reg_read(8'h03, 8'h81, "R6 id1");
      reg_read(8'h04, 8'h08, "R6 id2");
      reg_write(8'h02, 8'hFB, "R6");
      reg_read(8'h02, 8'hF3, "R6 ctrl");

      // R7 soft reset, R8 flag clear
      reg_write(8'h01, 8'h11, "R7");
      reg_write(8'h02, 8'h04, "R7");
      tick(4); chk("R7 bank", 64'(bank_q), 64'(DFLT | 48'h04_0000_0000_00));
      reg_read(8'h02, 8'h82, "R7 ctrl");
      reg_read(8'h05, 8'h04, "R8 first");
      reg_read(8'h05, 8'h00, "R8 second");

      // R12 status passthrough
      status_in = 8'hA5;
      reg_read(8'h05, 8'hA1, "R12");
      status_in = 8'h00;

      // R9 master code and HS mode
      bus_start(); send(8'h0B, "R9 code", 1'b1);
      bus_start(); tick(4);
      chk("R9 hs on", 64'(hs_mode), 64'd1);
      send(8'hC0, "R9", 1'b0); send(8'h01, "R9", 1'b0); send(8'h5A, "R9", 1'b0);
      chk("R9 hs held", 64'(hs_mode), 64'd1);
      bus_stop(); tick(4);
      chk("R9 hs off", 64'(hs_mode), 64'd0);
      chk("R9 reg1", 64'(bank_q[15:8]), 64'h5A);

      // R11 short clock glitch during a data bit
      bus_start(); send(8'hC0, "R11", 1'b0); send(8'h01, "R11", 1'b0);
      glitch_next = 1;
      send(8'h3C, "R11", 1'b0); bus_stop();
      tick(4); chk("R11 reg1", 64'(bank_q[15:8]), 64'h3C);

      while (exp_q.size() > 0 || obs_q.size() > 0) tick(1);
      chk("R10 oe changes while SCL high", 64'(oe_viol), 64'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule